// File: doc/BRIEF.md
# Escaped Serial Frame Decoder

This block sits behind a serial receiver and rebuilds data frames from the raw received byte stream. A configurable delimiter byte marks frame boundaries. Bytes that would collide with the delimiter or with flow-control characters arrive as two-byte escape pairs, and the decoder turns each pair back into its original byte. Four escape pairs are available. For each pair, the original byte, the lead byte, the code byte and an enable can all be set at runtime. Delimiter bytes are never forwarded. The last payload byte of every frame leaves with a last flag.

A frame can be closed by any of four sources: a delimiter byte, a line-idle strobe, a break strobe, or the payload count reaching a header length supplied on a side input. Each source has its own enable, except the delimiter, which is governed by its delimiter-enable bit. The decoder holds back one payload byte so that it can attach the last flag to it. A frame-start pulse marks an opening delimiter. An error pulse marks an escape lead byte that forms no enabled pair. A completion pulse fires when the payload count of a frame passes a threshold.

Both byte streams use valid/ready. A byte moves on a clock edge where valid and ready are both high. `in_ready` does not depend on `in_data`. It is low whenever the output holds a byte that has not been taken (`out_valid` high while `out_ready` is low). It is also low for one cycle after an escape error, while the second byte of the broken pair is forwarded. Once raised, `out_valid`, `out_data` and `out_last` hold steady until `out_ready` is seen high. No byte is dropped under back-pressure. The idle and break strobes have no handshake and take effect in the cycle they are high.

Top module: `esc_frame_decoder`

## Requirements
- R1: After reset `out_valid`, `esc_err`, `frame_start` and `rx_done` are 0 and `in_ready` is 1.
- R2: With `cfg_sep_en`=1, bytes equal to `cfg_sep_char` (0xC0 in use) are not forwarded. The payload between two delimiters leaves in order, and only its final byte has `out_last`=1.
- R3: Pair k occupies byte k of `cfg_pair_orig`, `cfg_pair_lead` and `cfg_pair_code` (bits 8k+7..8k) and bit k of `cfg_pair_en`. When pair k is enabled, the input sequence lead_k followed by code_k produces the single byte orig_k. The table in use is: k0 DB DC→C0, k1 DB DD→DB, k2 DB DE→11, k3 DB DF→13.
- R4: A pair whose enable bit is 0 is never decoded. Its lead/code sequence is handled as unmatched (R5).
- R5: A lead byte followed by a byte that completes no enabled pair makes the decoder forward the lead byte and then that second byte unchanged, and pulse `esc_err` for one cycle. The second byte is not examined as a new lead.
- R6: A lead byte followed by a delimiter byte makes the decoder forward the lead byte as data and pulse `esc_err`. The delimiter still acts on the frame.
- R7: A delimiter arriving while the current frame has no payload never produces an output byte. `frame_start` pulses once for such a delimiter only if no earlier delimiter has already opened the frame.
- R8: With `cfg_idle_end_en`=1, a `line_idle` strobe closes a frame that has payload, and the held byte leaves with `out_last`=1. With the enable at 0, or with an empty frame, the strobe has no effect.
- R9: With `cfg_len_end_en`=1, the payload byte whose count within the frame equals `hdr_len` leaves with `out_last`=1, and the count restarts. `hdr_len`=0 never closes a frame.
- R10: With `cfg_brk_end_en`=1, a `line_break` strobe closes a frame that has payload. With the enable at 0, the strobe has no effect.
- R11: `rx_done` pulses for one cycle when a payload byte makes the count within the frame equal to `cfg_done_thresh`+1.
- R12: With `cfg_sep_en`=0, a byte equal to `cfg_sep_char` is ordinary payload and raises no `frame_start`.
- R13: While `out_valid`=1 and `out_ready`=0, the output is held stable and `in_ready`=0. Under any `out_ready` pattern the byte sequence and the last flags match the unstalled result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Decoder accepts the byte |
| line_idle | input | 1 | One-cycle strobe: line has been idle |
| line_break | input | 1 | One-cycle strobe: break received |
| hdr_len | input | LEN_W | Payload length taken from the packet header |
| cfg_sep_char | input | 8 | Delimiter byte value |
| cfg_sep_en | input | 1 | Delimiter recognition enable |
| cfg_pair_orig | input | NPAIR*8 | Original byte of each escape pair |
| cfg_pair_lead | input | NPAIR*8 | First byte of each escape pair |
| cfg_pair_code | input | NPAIR*8 | Second byte of each escape pair |
| cfg_pair_en | input | NPAIR | Per-pair decode enable |
| cfg_idle_end_en | input | 1 | Idle strobe closes frame |
| cfg_len_end_en | input | 1 | Header length closes frame |
| cfg_brk_end_en | input | 1 | Break strobe closes frame |
| cfg_done_thresh | input | LEN_W | Completion threshold on payload count |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Decoded payload byte |
| out_last | output | 1 | Byte is the final one of its frame |
| out_ready | input | 1 | Consumer takes the byte |
| esc_err | output | 1 | Pulse: lead byte formed no enabled pair |
| frame_start | output | 1 | Pulse: opening delimiter seen |
| rx_done | output | 1 | Pulse: payload count passed the threshold |

## Verification
A stuck or stale held byte shows up at the next frame boundary as a missing, duplicated or misplaced last flag, within one cycle of the delimiter or strobe. A lead-pending state that is left set, or cleared too early, corrupts the very next decoded byte, or it raises or suppresses `esc_err` on that byte. Drift in the payload counter moves the length-based end and the `rx_done` pulse to the wrong byte within the same frame. A fault in the output slot under back-pressure appears as a lost or repeated byte in the stream compared against the unstalled run.

// File: rtl/esc_dec_pkg.sv
package esc_dec_pkg;
  localparam int BYTE_W = 8;

  // One decoded item handed from the unescaper to the frame tracker.
  typedef struct packed {
    logic              is_sep;
    logic [BYTE_W-1:0] data;
  } sym_t;
endpackage

// File: rtl/esc_pair_match.sv
module esc_pair_match
  import esc_dec_pkg::*;
(
  input  logic              en,
  input  logic [BYTE_W-1:0] lead,
  input  logic [BYTE_W-1:0] code,
  input  logic [BYTE_W-1:0] cur_byte,
  input  logic [BYTE_W-1:0] held_lead,
  output logic              is_lead,
  output logic              is_code
);
  // The current byte may open this pair.
  assign is_lead = en && (cur_byte == lead);
  // The current byte completes this pair after the stored lead.
  assign is_code = en && (held_lead == lead) && (cur_byte == code);
endmodule

// File: rtl/esc_unescaper.sv
module esc_unescaper
  import esc_dec_pkg::*;
#(
  parameter int NPAIR = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [BYTE_W-1:0]       in_data,
  output logic                    in_ready,
  input  logic [BYTE_W-1:0]       sep_char,
  input  logic                    sep_en,
  input  logic [NPAIR*BYTE_W-1:0] pair_orig,
  input  logic [NPAIR*BYTE_W-1:0] pair_lead,
  input  logic [NPAIR*BYTE_W-1:0] pair_code,
  input  logic [NPAIR-1:0]        pair_en,
  output logic                    sym_valid,
  output sym_t                    sym,
  input  logic                    sym_ready,
  output logic                    esc_err
);
  logic              lead_pend;
  logic [BYTE_W-1:0] lead_byte;
  logic              stash_v;
  sym_t              stash;
  logic              err_q;

  logic [NPAIR-1:0]  lead_vec;
  logic [NPAIR-1:0]  code_vec;
  logic              lead_any;
  logic              code_hit;
  logic [BYTE_W-1:0] orig_sel;
  logic              is_sep;
  logic              take_lead;
  logic              make_err;
  logic              accept;

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    esc_pair_match u_match (
      .en        (pair_en[k]),
      .lead      (pair_lead[k*BYTE_W +: BYTE_W]),
      .code      (pair_code[k*BYTE_W +: BYTE_W]),
      .cur_byte  (in_data),
      .held_lead (lead_byte),
      .is_lead   (lead_vec[k]),
      .is_code   (code_vec[k])
    );
  end

  // Lowest-numbered matching pair wins.
  always_comb begin
    code_hit = 1'b0;
    orig_sel = '0;
    for (int k = NPAIR - 1; k >= 0; k--) begin
      if (code_vec[k]) begin
        code_hit = 1'b1;
        orig_sel = pair_orig[k*BYTE_W +: BYTE_W];
      end
    end
  end

  assign lead_any = |lead_vec;
  assign is_sep   = sep_en && (in_data == sep_char);
  assign in_ready = !stash_v && sym_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    sym_valid = 1'b0;
    sym       = '0;
    take_lead = 1'b0;
    make_err  = 1'b0;
    if (stash_v) begin
      sym_valid = 1'b1;
      sym       = stash;
    end else if (in_valid) begin
      if (lead_pend) begin
        sym_valid   = 1'b1;
        sym.is_sep  = 1'b0;
        if (code_hit) begin
          sym.data = orig_sel;
        end else begin
          sym.data = lead_byte;
          make_err = 1'b1;
        end
      end else if (is_sep) begin
        sym_valid  = 1'b1;
        sym.is_sep = 1'b1;
        sym.data   = in_data;
      end else if (lead_any) begin
        take_lead = 1'b1;
      end else begin
        sym_valid = 1'b1;
        sym.data  = in_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_pend <= 1'b0;
      lead_byte <= '0;
      stash_v   <= 1'b0;
      stash     <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= accept && make_err;
      if (stash_v && sym_ready) stash_v <= 1'b0;
      if (accept) begin
        if (lead_pend) begin
          lead_pend <= 1'b0;
          if (make_err) begin
            stash_v      <= 1'b1;
            stash.is_sep <= is_sep;
            stash.data   <= in_data;
          end
        end else if (take_lead) begin
          lead_pend <= 1'b1;
          lead_byte <= in_data;
        end
      end
    end
  end

  assign esc_err = err_q;

  // R5: after an error the stashed byte blocks input, so errors never repeat back to back
  p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    esc_err |=> !esc_err);

  // R5: while the stashed second byte is pending, a symbol is always offered
  p_stash_offered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(esc_err) |-> sym_valid);
endmodule

// File: rtl/esc_frame_tracker.sv
module esc_frame_tracker
  import esc_dec_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_valid,
  input  sym_t              sym,
  output logic              sym_ready,
  input  logic              idle_evt,
  input  logic              brk_evt,
  input  logic              idle_en,
  input  logic              brk_en,
  input  logic              len_en,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic [LEN_W-1:0]  done_thresh,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  input  logic              out_ready,
  output logic              sof,
  output logic              rx_done
);
  localparam int CNT_W = LEN_W + 1;

  logic              out_v;
  logic [BYTE_W-1:0] out_d;
  logic              out_l;
  logic              hold_v;
  logic [BYTE_W-1:0] hold_d;
  logic              hold_last;
  logic              opened;
  logic [CNT_W-1:0]  cnt;
  logic              sof_q;
  logic              done_q;

  logic              slot_free;
  logic              fire;
  logic              dfire;
  logic              sfire;
  logic              open_frame;
  logic              end_evt;
  logic              move;
  logic [CNT_W-1:0]  cnt_inc;
  logic [CNT_W-1:0]  done_at;
  logic              len_hit;
  logic              close_new;

  always_comb begin
    slot_free  = !out_v || out_ready;
    fire       = sym_valid && slot_free;
    dfire      = fire && !sym.is_sep;
    sfire      = fire && sym.is_sep;
    open_frame = hold_v && !hold_last;
    end_evt    = (idle_evt && idle_en) || (brk_evt && brk_en);
    move       = hold_v && slot_free && (hold_last || fire);
    cnt_inc    = (&cnt) ? cnt : cnt + CNT_W'(1);
    done_at    = {1'b0, done_thresh} + CNT_W'(1);
    len_hit    = len_en && (cnt_inc == {1'b0, hdr_len});
    close_new  = end_evt || len_hit;
  end

  assign sym_ready = slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v     <= 1'b0;
      out_d     <= '0;
      out_l     <= 1'b0;
      hold_v    <= 1'b0;
      hold_d    <= '0;
      hold_last <= 1'b0;
      opened    <= 1'b0;
      cnt       <= '0;
      sof_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      sof_q  <= sfire && !open_frame && !opened;
      done_q <= dfire && (cnt_inc == done_at);

      if (out_v && out_ready) out_v <= 1'b0;
      if (move) begin
        out_v <= 1'b1;
        out_d <= hold_d;
        out_l <= hold_last || sfire;
      end

      if (dfire) begin
        hold_v    <= 1'b1;
        hold_d    <= sym.data;
        hold_last <= close_new;
        cnt       <= close_new ? '0 : cnt_inc;
        if (close_new) opened <= 1'b0;
      end else begin
        if (move) begin
          hold_v    <= 1'b0;
          hold_last <= 1'b0;
        end
        if (sfire) begin
          if (open_frame) begin
            cnt    <= '0;
            opened <= 1'b0;
          end else if (!opened) begin
            opened <= 1'b1;
          end
        end else if (end_evt && open_frame) begin
          hold_last <= 1'b1;
          cnt       <= '0;
          opened    <= 1'b0;
        end
      end
    end
  end

  assign out_valid = out_v;
  assign out_data  = out_d;
  assign out_last  = out_l;
  assign sof       = sof_q;
  assign rx_done   = done_q;

  // R13: a stalled output byte stays put
  p_stall_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R8: a held byte marked final reaches the output with the last flag
  p_flush_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v && hold_last && slot_free |=> out_valid && out_last);

  // R7: extra delimiters after an opening one raise no second pulse
  p_sof_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !sof);

  // R11: the completion pulse fires on one byte only
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
endmodule

// File: rtl/esc_frame_decoder.sv
module esc_frame_decoder
  import esc_dec_pkg::*;
#(
  parameter int NPAIR = 4,
  parameter int LEN_W = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [BYTE_W-1:0]       in_data,
  output logic                    in_ready,
  input  logic                    line_idle,
  input  logic                    line_break,
  input  logic [LEN_W-1:0]        hdr_len,
  input  logic [BYTE_W-1:0]       cfg_sep_char,
  input  logic                    cfg_sep_en,
  input  logic [NPAIR*BYTE_W-1:0] cfg_pair_orig,
  input  logic [NPAIR*BYTE_W-1:0] cfg_pair_lead,
  input  logic [NPAIR*BYTE_W-1:0] cfg_pair_code,
  input  logic [NPAIR-1:0]        cfg_pair_en,
  input  logic                    cfg_idle_end_en,
  input  logic                    cfg_len_end_en,
  input  logic                    cfg_brk_end_en,
  input  logic [LEN_W-1:0]        cfg_done_thresh,
  output logic                    out_valid,
  output logic [BYTE_W-1:0]       out_data,
  output logic                    out_last,
  input  logic                    out_ready,
  output logic                    esc_err,
  output logic                    frame_start,
  output logic                    rx_done
);
  logic sym_valid;
  sym_t sym;
  logic sym_ready;

  esc_unescaper #(.NPAIR(NPAIR)) u_unesc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .sep_char  (cfg_sep_char),
    .sep_en    (cfg_sep_en),
    .pair_orig (cfg_pair_orig),
    .pair_lead (cfg_pair_lead),
    .pair_code (cfg_pair_code),
    .pair_en   (cfg_pair_en),
    .sym_valid (sym_valid),
    .sym       (sym),
    .sym_ready (sym_ready),
    .esc_err   (esc_err)
  );

  esc_frame_tracker #(.LEN_W(LEN_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_valid   (sym_valid),
    .sym         (sym),
    .sym_ready   (sym_ready),
    .idle_evt    (line_idle),
    .brk_evt     (line_break),
    .idle_en     (cfg_idle_end_en),
    .brk_en      (cfg_brk_end_en),
    .len_en      (cfg_len_end_en),
    .hdr_len     (hdr_len),
    .done_thresh (cfg_done_thresh),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_last    (out_last),
    .out_ready   (out_ready),
    .sof         (frame_start),
    .rx_done     (rx_done)
  );

  // R13: input is refused while the output slot is stalled
  p_backpressure_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/esc_frame_decoder_tb.sv
module esc_frame_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPAIR      = 4;
  localparam int LEN_W      = 13;
  localparam int WD_LIMIT   = 100000;

  logic                 clk;
  logic                 rst_n;
  logic                 in_valid;
  logic [7:0]           in_data;
  logic                 in_ready;
  logic                 line_idle;
  logic                 line_break;
  logic [LEN_W-1:0]     hdr_len;
  logic [7:0]           cfg_sep_char;
  logic                 cfg_sep_en;
  logic [NPAIR*8-1:0]   cfg_pair_orig;
  logic [NPAIR*8-1:0]   cfg_pair_lead;
  logic [NPAIR*8-1:0]   cfg_pair_code;
  logic [NPAIR-1:0]     cfg_pair_en;
  logic                 cfg_idle_end_en;
  logic                 cfg_len_end_en;
  logic                 cfg_brk_end_en;
  logic [LEN_W-1:0]     cfg_done_thresh;
  logic                 out_valid;
  logic [7:0]           out_data;
  logic                 out_last;
  logic                 out_ready;
  logic                 esc_err;
  logic                 frame_start;
  logic                 rx_done;

  int         n_checks = 0;
  int         n_fail   = 0;
  int         cyc      = 0;
  int         n_err    = 0;
  int         n_sof    = 0;
  int         n_done   = 0;
  logic       bp       = 1'b0;
  bit         finished = 1'b0;
  logic [8:0] got_q[$];
  logic [8:0] exp_q[$];

  esc_frame_decoder #(.NPAIR(NPAIR), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .line_idle(line_idle), .line_break(line_break),
    .hdr_len(hdr_len), .cfg_sep_char(cfg_sep_char), .cfg_sep_en(cfg_sep_en),
    .cfg_pair_orig(cfg_pair_orig), .cfg_pair_lead(cfg_pair_lead),
    .cfg_pair_code(cfg_pair_code), .cfg_pair_en(cfg_pair_en),
    .cfg_idle_end_en(cfg_idle_end_en), .cfg_len_end_en(cfg_len_end_en),
    .cfg_brk_end_en(cfg_brk_end_en), .cfg_done_thresh(cfg_done_thresh),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .esc_err(esc_err), .frame_start(frame_start),
    .rx_done(rx_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Output monitor: ready is set at the falling edge and the handshake
  // completes at the following rising edge.
  always @(negedge clk) begin
    cyc++;
    out_ready = bp ? ((cyc % 3) == 0) : 1'b1;
    if (rst_n && out_valid && out_ready) got_q.push_back({out_last, out_data});
    if (rst_n && esc_err)     n_err++;
    if (rst_n && frame_start) n_sof++;
    if (rst_n && rx_done)     n_done++;
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    if (cyc > WD_LIMIT && !finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got cycle %0d expected below %0d", cyc, WD_LIMIT);
      report();
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic ex(input logic [7:0] d, input logic l);
    exp_q.push_back({l, d});
  endtask

  task automatic cmp_stream(input string tag);
    chk({tag, " byte count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk($sformatf("%s item %0d {last,data}", tag, i), int'(got_q[i]), int'(exp_q[i]));
  endtask

  task automatic send(input logic [7:0] b);
    bit done;
    done = 1'b0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!done) begin
      #1;
      if (in_ready) begin
        @(posedge clk);
        done = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic pulse_idle();
    @(negedge clk);
    in_valid  = 1'b0;
    line_idle = 1'b1;
    @(negedge clk);
    line_idle = 1'b0;
  endtask

  task automatic pulse_brk();
    @(negedge clk);
    in_valid   = 1'b0;
    line_break = 1'b1;
    @(negedge clk);
    line_break = 1'b0;
  endtask

  task automatic drain(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic defaults();
    cfg_sep_char    = 8'hC0;
    cfg_sep_en      = 1'b1;
    cfg_pair_orig   = {8'h13, 8'h11, 8'hDB, 8'hC0};
    cfg_pair_lead   = {8'hDB, 8'hDB, 8'hDB, 8'hDB};
    cfg_pair_code   = {8'hDF, 8'hDE, 8'hDD, 8'hDC};
    cfg_pair_en     = 4'hF;
    cfg_idle_end_en = 1'b0;
    cfg_len_end_en  = 1'b0;
    cfg_brk_end_en  = 1'b0;
    hdr_len         = '0;
    cfg_done_thresh = '1;
    bp              = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    in_data    = 8'h00;
    line_idle  = 1'b0;
    line_break = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    got_q.delete();
    exp_q.delete();
    n_err  = 0;
    n_sof  = 0;
    n_done = 0;
  endtask

  task automatic t_reset();
    defaults();
    do_reset();
    #1;
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 esc_err", int'(esc_err), 0);
    chk("R1 frame_start", int'(frame_start), 0);
    chk("R1 rx_done", int'(rx_done), 0);
  endtask

  task automatic t_basic();
    defaults(); do_reset();
    send(8'hC0); send(8'h41); send(8'h42); send(8'h43); send(8'hC0);
    drain(10);
    ex(8'h41, 0); ex(8'h42, 0); ex(8'h43, 1);
    cmp_stream("R2 delimited frame");
    chk("R2 frame_start count", n_sof, 1);
    chk("R2 esc_err count", n_err, 0);
  endtask

  task automatic t_escapes(input logic use_bp, input string tag);
    defaults(); do_reset();
    bp = use_bp;
    send(8'hC0);
    send(8'hDB); send(8'hDC); send(8'hDB); send(8'hDD);
    send(8'hDB); send(8'hDE); send(8'hDB); send(8'hDF);
    send(8'h5A); send(8'hC0);
    send(8'hC0); send(8'h61); send(8'h62); send(8'hC0);
    drain(40);
    ex(8'hC0, 0); ex(8'hDB, 0); ex(8'h11, 0); ex(8'h13, 0); ex(8'h5A, 1);
    ex(8'h61, 0); ex(8'h62, 1);
    cmp_stream(tag);
    chk({tag, " esc_err count"}, n_err, 0);
  endtask

  task automatic t_disabled();
    defaults(); cfg_pair_en = 4'b1011; do_reset();
    send(8'hC0); send(8'hDB); send(8'hDC); send(8'hDB); send(8'hDE);
    send(8'h77); send(8'hC0);
    drain(10);
    ex(8'hC0, 0); ex(8'hDB, 0); ex(8'hDE, 0); ex(8'h77, 1);
    cmp_stream("R4 disabled pair");
    chk("R4 esc_err count", n_err, 1);
  endtask

  task automatic t_unmatched();
    defaults(); do_reset();
    send(8'hC0); send(8'hDB); send(8'h55); send(8'hC0);
    send(8'hDB); send(8'hDB); send(8'hDC); send(8'hC0);
    drain(10);
    ex(8'hDB, 0); ex(8'h55, 1);
    ex(8'hDB, 0); ex(8'hDB, 0); ex(8'hDC, 1);
    cmp_stream("R5 unmatched pair");
    chk("R5 esc_err count", n_err, 2);
    chk("R5 frame_start count", n_sof, 1);
  endtask

  task automatic t_lead_sep();
    defaults(); do_reset();
    send(8'hC0); send(8'h41); send(8'hDB); send(8'hC0); send(8'h42); send(8'hC0);
    drain(10);
    ex(8'h41, 0); ex(8'hDB, 1); ex(8'h42, 1);
    cmp_stream("R6 lead then delimiter");
    chk("R6 esc_err count", n_err, 1);
  endtask

  task automatic t_b2b();
    defaults(); do_reset();
    send(8'hC0); send(8'hC0); send(8'h41); send(8'hC0);
    send(8'hC0); send(8'hC0); send(8'h42); send(8'hC0);
    drain(10);
    ex(8'h41, 1); ex(8'h42, 1);
    cmp_stream("R7 repeated delimiters");
    chk("R7 frame_start count", n_sof, 2);
  endtask

  task automatic t_idle();
    defaults(); cfg_idle_end_en = 1'b1; do_reset();
    send(8'hC0); send(8'h41); send(8'h42); pulse_idle();
    drain(5);
    chk("R8 idle closes frame count", got_q.size(), 2);
    pulse_idle();
    drain(5);
    chk("R8 idle on empty frame", got_q.size(), 2);
    cfg_idle_end_en = 1'b0;
    send(8'h43); pulse_idle();
    drain(5);
    chk("R8 idle disabled holds byte", got_q.size(), 2);
    send(8'hC0);
    drain(5);
    ex(8'h41, 0); ex(8'h42, 1); ex(8'h43, 1);
    cmp_stream("R8 idle end");
    chk("R8 frame_start count", n_sof, 1);
  endtask

  task automatic t_len();
    defaults(); cfg_len_end_en = 1'b1; hdr_len = 13'd3; do_reset();
    for (int i = 0; i < 6; i++) send(8'h41 + 8'(i));
    drain(10);
    ex(8'h41, 0); ex(8'h42, 0); ex(8'h43, 1);
    ex(8'h44, 0); ex(8'h45, 0); ex(8'h46, 1);
    cmp_stream("R9 length end");
    chk("R9 frame_start count", n_sof, 0);
  endtask

  task automatic t_len_zero();
    defaults(); cfg_len_end_en = 1'b1; hdr_len = 13'd0; do_reset();
    send(8'h41); send(8'h42);
    drain(8);
    chk("R9 zero length never closes", got_q.size(), 1);
    send(8'hC0);
    drain(5);
    ex(8'h41, 0); ex(8'h42, 1);
    cmp_stream("R9 zero length");
  endtask

  task automatic t_brk();
    defaults(); cfg_brk_end_en = 1'b1; do_reset();
    send(8'hC0); send(8'h51); send(8'h52); pulse_brk();
    drain(5);
    chk("R10 break closes frame count", got_q.size(), 2);
    cfg_brk_end_en = 1'b0;
    send(8'h53); pulse_brk();
    drain(5);
    chk("R10 break disabled holds byte", got_q.size(), 2);
    send(8'hC0);
    drain(5);
    ex(8'h51, 0); ex(8'h52, 1); ex(8'h53, 1);
    cmp_stream("R10 break end");
  endtask

  task automatic t_done();
    defaults(); cfg_done_thresh = 13'd2; do_reset();
    send(8'hC0); send(8'h41); send(8'h42); send(8'h43); send(8'h44); send(8'hC0);
    drain(5);
    chk("R11 rx_done after count passes threshold", n_done, 1);
    send(8'h45); send(8'h46); send(8'hC0);
    drain(5);
    chk("R11 rx_done not for short frame", n_done, 1);
  endtask

  task automatic t_nosep();
    defaults(); cfg_sep_en = 1'b0; cfg_idle_end_en = 1'b1; do_reset();
    send(8'hC0); send(8'h41); send(8'hC0); pulse_idle();
    drain(5);
    ex(8'hC0, 0); ex(8'h41, 0); ex(8'hC0, 1);
    cmp_stream("R12 delimiter disabled");
    chk("R12 frame_start count", n_sof, 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    line_idle = 1'b0; line_break = 1'b0; out_ready = 1'b1;
    defaults();
    t_reset();
    t_basic();
    t_escapes(1'b0, "R3 escape decode");
    t_disabled();
    t_unmatched();
    t_lead_sep();
    t_b2b();
    t_idle();
    t_len();
    t_len_zero();
    t_brk();
    t_done();
    t_nosep();
    t_escapes(1'b1, "R13 stalled output");
    if (!finished) begin
      finished = 1'b1;
      report();
      $finish;
    end
  end
endmodule